// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers a bank of peripheral interrupt lines and steers each one to a small set of parent interrupt outputs and core interrupt outputs. Every source first crosses two flip-flops into the clock domain. It is then qualified as an active-high level, an active-low level, a rising edge or a falling edge. An edge-mode source holds a sticky pending flag that software clears.

Each source has one routing byte. Its lower four bits choose the cores the source reaches, and its upper four bits choose the parent lines. A source can be switched on and off through two write-one registers, one that sets enables and one that clears them, so no read-modify-write is needed. The register interface is a plain word-wide bus with combinational read data. Byte lane enables apply only to the routing bytes.

Top module: `routed_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all enables, polarity bits, edge bits, routing bytes and edge flags are zero, both output groups are low, and every readable register returns zero.
- R2: The routing byte of source n is at byte address n, within 0x00 to 0x1F. It is reached through the aligned word at n rounded down to a multiple of 4, in bits 8*(n mod 4) to 8*(n mod 4)+7. It is written only where the matching bus_be lane is 1, and it reads back in the same position. Addresses that are not mapped read as zero.
- R3: Writing the word at 0x28 sets the enable of each source whose data bit is 1 and leaves the others unchanged. Enables read back at 0x24, bit n for source n. Reads of 0x28 and 0x2C return zero.
- R4: Writing the word at 0x2C clears the enable of each source whose data bit is 1 and leaves the others unchanged.
- R5: Bit n of the word at 0x34 (edge) and bit n of the word at 0x30 (polarity) select the trigger of source n: 00 is level active-low, 01 is level active-high, 11 is rising edge, 10 is falling edge. A level source is active while its synchronised input equals its polarity bit.
- R6: An edge source raises its flag on the third rising clock after the selected input transition. The flag stays set until 1 is written to its bit at 0x40. Placing the source in level mode discards the flag.
- R7: If a new edge and a write-one-clear of the same source's flag act in the same cycle, the flag stays set.
- R8: Reading 0x40 returns the set of sources that are active and also enabled.
- R9: par_irq[k] is the OR of all active, enabled sources whose routing byte has bit 4+k set.
- R10: core_irq[c] is the OR of all active, enabled sources whose routing byte has bit c set. A disabled source drives neither output group.
- R11: A level input change reaches the outputs after the second rising clock and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | NSRC | Raw peripheral interrupt inputs, asynchronous |
| bus_wen | input | 1 | Write strobe for the current bus address |
| bus_addr | input | 8 | Byte address of the register access |
| bus_be | input | 4 | Byte lane enables, used by routing words |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| par_irq | output | NPAR | Parent interrupt outputs |
| core_irq | output | NCORE | Core interrupt outputs |

## Verification
Edge capture and the write-one-clear of the status register can act on the same flag at the same clock edge. The bench arranges this by raising a source's input, waiting exactly two clocks, and then presenting a clear of that bit so that the write meets the capturing edge. The flag must still read as set afterwards. A behavioural model, updated at every clock, also compares both output groups and the read data of whichever address is on the bus.

// File: rtl/rirq_pkg.sv
package rirq_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;
    localparam int LANES  = BUS_DW / 8;

    localparam logic [BUS_AW-1:0] A_EN_STAT  = 8'h24;
    localparam logic [BUS_AW-1:0] A_EN_SET   = 8'h28;
    localparam logic [BUS_AW-1:0] A_EN_CLR   = 8'h2C;
    localparam logic [BUS_AW-1:0] A_POL      = 8'h30;
    localparam logic [BUS_AW-1:0] A_EDGE     = 8'h34;
    localparam logic [BUS_AW-1:0] A_STAT     = 8'h40;
    localparam logic [BUS_AW-1:0] A_ROUTE_HI = 8'h20;

    // {edge, polarity}
    typedef enum logic [1:0] {
        TRIG_LVL_LO   = 2'b00,
        TRIG_LVL_HI   = 2'b01,
        TRIG_FALLING  = 2'b10,
        TRIG_RISING   = 2'b11
    } trig_e;

    typedef struct packed {
        logic [3:0] par;
        logic [3:0] core;
    } route_t;

    typedef struct packed {
        logic              wen;
        logic [BUS_AW-1:0] addr;
        logic [LANES-1:0]  be;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    function automatic trig_e make_trig(input logic is_edge, input logic pol);
        return trig_e'({is_edge, pol});
    endfunction

    function automatic logic [BUS_AW-1:0] route_word_addr(input int idx);
        return BUS_AW'((idx / LANES) * LANES);
    endfunction

endpackage

// File: rtl/rirq_src.sv
module rirq_src
    import rirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  irq_i,
    input  trig_e trig,
    input  logic  clr_i,
    output logic  pend_o,
    output logic  lat_o
);
    logic sync1, sync2, prev, lat;
    logic is_edge, hit;

    assign is_edge = (trig == TRIG_RISING) || (trig == TRIG_FALLING);
    assign hit     = (trig == TRIG_RISING) ? (sync2 & ~prev) : (~sync2 & prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
            lat   <= 1'b0;
        end else begin
            sync1 <= irq_i;
            sync2 <= sync1;
            prev  <= sync2;
            if (!is_edge)
                lat <= 1'b0;
            else if (hit)
                lat <= 1'b1;      // capture wins over a clear in the same cycle
            else if (clr_i)
                lat <= 1'b0;
        end
    end

    assign pend_o = is_edge ? lat : (sync2 == trig[0]);
    assign lat_o  = lat;
endmodule

// File: rtl/rirq_regs.sv
module rirq_regs
    import rirq_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [NSRC-1:0]   pend,
    output logic [NSRC-1:0]   en,
    output logic [NSRC-1:0]   pol,
    output logic [NSRC-1:0]   edg,
    output route_t            route [NSRC],
    output logic [NSRC-1:0]   clr,
    output logic [BUS_DW-1:0] rdata
);
    logic [NSRC-1:0] wd;
    assign wd = req.wdata[NSRC-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= '0;
            pol <= '0;
            edg <= '0;
        end else if (req.wen) begin
            case (req.addr)
                A_EN_SET: en  <= en | wd;
                A_EN_CLR: en  <= en & ~wd;
                A_POL:    pol <= wd;
                A_EDGE:   edg <= wd;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_route
        localparam int LANE = i % LANES;
        always_ff @(posedge clk) begin
            if (rst)
                route[i] <= '0;
            else if (req.wen && req.addr == route_word_addr(i) && req.be[LANE])
                route[i] <= req.wdata[8*LANE +: 8];
        end
    end

    assign clr = (req.wen && req.addr == A_STAT) ? wd : '0;

    always_comb begin
        rdata = '0;
        case (req.addr)
            A_EN_STAT: rdata = BUS_DW'(en);
            A_POL:     rdata = BUS_DW'(pol);
            A_EDGE:    rdata = BUS_DW'(edg);
            A_STAT:    rdata = BUS_DW'(pend & en);
            default: begin
                if (req.addr < A_ROUTE_HI && req.addr[1:0] == 2'b00) begin
                    for (int j = 0; j < LANES; j++) begin
                        int idx;
                        idx = int'(req.addr[4:2]) * LANES + j;
                        if (idx < NSRC)
                            rdata[8*j +: 8] = route[idx];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/rirq_route.sv
module rirq_route
    import rirq_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NPAR  = 4,
    parameter int NCORE = 4
) (
    input  logic [NSRC-1:0]  act,
    input  route_t           route [NSRC],
    output logic [NPAR-1:0]  par,
    output logic [NCORE-1:0] core
);
    always_comb begin
        par  = '0;
        core = '0;
        for (int i = 0; i < NSRC; i++) begin
            for (int k = 0; k < NPAR; k++)
                par[k] = par[k] | (act[i] & route[i].par[k]);
            for (int c = 0; c < NCORE; c++)
                core[c] = core[c] | (act[i] & route[i].core[c]);
        end
    end
endmodule

// File: rtl/routed_irq_ctrl.sv
module routed_irq_ctrl
    import rirq_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NPAR  = 4,
    parameter int NCORE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   irq_in,
    input  logic              bus_wen,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic [NPAR-1:0]   par_irq,
    output logic [NCORE-1:0]  core_irq
);
    bus_req_t        req;
    logic [NSRC-1:0] src_en, src_pol, src_edge, src_clr, src_pend, src_latch;
    route_t          src_route [NSRC];

    assign req = '{wen: bus_wen, addr: bus_addr, be: bus_be, wdata: bus_wdata};

    rirq_regs #(.NSRC(NSRC)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .pend  (src_pend),
        .en    (src_en),
        .pol   (src_pol),
        .edg   (src_edge),
        .route (src_route),
        .clr   (src_clr),
        .rdata (bus_rdata)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        rirq_src u_src (
            .clk    (clk),
            .rst    (rst),
            .irq_i  (irq_in[i]),
            .trig   (make_trig(src_edge[i], src_pol[i])),
            .clr_i  (src_clr[i]),
            .pend_o (src_pend[i]),
            .lat_o  (src_latch[i])
        );
    end

    rirq_route #(.NSRC(NSRC), .NPAR(NPAR), .NCORE(NCORE)) u_route (
        .act   (src_pend & src_en),
        .route (src_route),
        .par   (par_irq),
        .core  (core_irq)
    );
endmodule

// File: rtl/rirq_chk.sv
module rirq_chk #(
    parameter int NSRC  = 32,
    parameter int NPAR  = 4,
    parameter int NCORE = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wen,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [NSRC-1:0]  src_en,
    input logic [NSRC-1:0]  src_edge,
    input logic [NSRC-1:0]  src_latch,
    input logic [NPAR-1:0]  par_irq,
    input logic [NCORE-1:0] core_irq
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (src_en == '0 && src_edge == '0 && src_latch == '0)); // R1

    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == 8'h28) |=>
        ((src_en & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R3

    AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == 8'h2C) |=>
        ((src_en & $past(bus_wdata[NSRC-1:0])) == '0)); // R4

    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_wen && (bus_addr == 8'h28 || bus_addr == 8'h2C)) |=> $stable(src_en)); // R3

    AST_LEVEL_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (src_latch & ~$past(src_edge)) == '0); // R6

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (src_en == '0) |-> (par_irq == '0 && core_irq == '0)); // R10
endmodule

bind routed_irq_ctrl rirq_chk #(.NSRC(NSRC), .NPAR(NPAR), .NCORE(NCORE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .src_en    (src_en),
    .src_edge  (src_edge),
    .src_latch (src_latch),
    .par_irq   (par_irq),
    .core_irq  (core_irq)
);

// File: tb/sim_routed_irq_ctrl.sv
module sim_routed_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  par_irq, core_irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    routed_irq_ctrl u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .par_irq(par_irq), .core_irq(core_irq)
    );

    // behavioural reference
    logic [31:0] m_en, m_pol, m_edge, m_s1, m_s2, m_prev, m_lat;
    logic [7:0]  m_route [32];

    function automatic logic [31:0] m_act();
        logic [31:0] a;
        for (int i = 0; i < 32; i++)
            a[i] = m_en[i] & (m_edge[i] ? m_lat[i] : (m_s2[i] == m_pol[i]));
        return a;
    endfunction

    function automatic logic [31:0] m_rd(input logic [7:0] a);
        case (a)
            8'h24: return m_en;
            8'h30: return m_pol;
            8'h34: return m_edge;
            8'h40: return m_act();
            default:
                if (a < 8'h20 && a[1:0] == 2'b00)
                    return {m_route[a[4:2]*4+3], m_route[a[4:2]*4+2],
                            m_route[a[4:2]*4+1], m_route[a[4:2]*4]};
                else
                    return 32'h0;
        endcase
    endfunction

    function automatic logic [7:0] m_out();
        logic [31:0] a;
        logic [7:0]  o;
        a = m_act();
        o = '0;
        for (int i = 0; i < 32; i++)
            if (a[i]) o = o | {m_route[i][7:4], m_route[i][3:0]};
        return o;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en <= '0; m_pol <= '0; m_edge <= '0;
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_lat <= '0;
            for (int i = 0; i < 32; i++) m_route[i] <= '0;
        end else begin
            m_s1 <= irq_in; m_s2 <= m_s1; m_prev <= m_s2;
            for (int i = 0; i < 32; i++) begin
                if (!m_edge[i]) m_lat[i] <= 1'b0;
                else if (m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]))
                    m_lat[i] <= 1'b1;
                else if (bus_wen && bus_addr == 8'h40 && bus_wdata[i])
                    m_lat[i] <= 1'b0;
            end
            if (bus_wen) begin
                case (bus_addr)
                    8'h28: m_en <= m_en | bus_wdata;
                    8'h2C: m_en <= m_en & ~bus_wdata;
                    8'h30: m_pol <= bus_wdata;
                    8'h34: m_edge <= bus_wdata;
                    default:
                        if (bus_addr < 8'h20 && bus_addr[1:0] == 2'b00)
                            for (int b = 0; b < 4; b++)
                                if (bus_be[b]) m_route[bus_addr[4:2]*4+b] <= bus_wdata[8*b +: 8];
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        chk("R9 par_irq vs model", 32'(par_irq), 32'(m_out() >> 4));
        chk("R10 core_irq vs model", 32'(core_irq), 32'(m_out() & 8'h0F));
        chk("R2/R3/R8 rdata vs model", bus_rdata, m_rd(bus_addr));
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wen = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_neg(3);
        rst = 1'b0;
        // R1 reset state
        rd(8'h24, 32'h0, "R1 enables");
        rd(8'h30, 32'h0, "R1 polarity");
        rd(8'h34, 32'h0, "R1 edge");
        rd(8'h1C, 32'h0, "R1 routing");
        chk("R1 outputs", 32'({par_irq, core_irq}), 32'h0);

        // R2 routing bytes with lane enables
        wr(8'h00, 32'hAAAA_2211, 4'b0001);
        wr(8'h00, 32'hBBBB_22FF, 4'b0010);
        rd(8'h00, 32'h0000_2211, "R2 lane write src0/src1");
        wr(8'h1C, 32'h8100_0000, 4'b1000);
        wr(8'h08, 32'h0048_0000, 4'b0100);
        rd(8'h08, 32'h0048_0000, "R2 src10 byte");
        rd(8'h1C, 32'h8100_0000, "R2 src31 byte");
        rd(8'h50, 32'h0, "R2 unmapped");

        // R3 enable set
        wr(8'h30, 32'hFFFF_FFFF, 4'hF);
        wr(8'h28, 32'h8000_0403, 4'hF);
        rd(8'h24, 32'h8000_0403, "R3 enable readback");
        rd(8'h28, 32'h0, "R3 set reg reads zero");

        // R11 / R9 / R10 level high on src0
        @(negedge clk); irq_in[0] = 1'b1;
        @(negedge clk);
        chk("R11 not after one clock", 32'(par_irq), 32'h0);
        @(negedge clk);
        chk("R11 R9 par after two clocks", 32'(par_irq), 32'h1);
        chk("R10 core src0", 32'(core_irq), 32'h1);

        @(negedge clk); irq_in[10] = 1'b1;
        wait_neg(2);
        chk("R9 two parents", 32'(par_irq), 32'h5);
        chk("R10 two cores", 32'(core_irq), 32'h9);

        // R4 enable clear
        wr(8'h2C, 32'h1, 4'hF);
        chk("R4 src0 silenced par", 32'(par_irq), 32'h4);
        rd(8'h24, 32'h8000_0402, "R4 enable readback");

        // R5 active-low level on src31
        wr(8'h30, 32'h7FFF_FFFF, 4'hF);
        chk("R5 active-low par", 32'(par_irq), 32'hC);
        chk("R5 active-low core", 32'(core_irq), 32'h9);
        rd(8'h40, 32'h8000_0400, "R8 status masks disabled src0");

        // R6 rising edge on src1
        wr(8'h34, 32'h2, 4'hF);
        @(negedge clk); irq_in[1] = 1'b1;
        @(negedge clk); irq_in[1] = 1'b0;
        wait_neg(4);
        rd(8'h40, 32'h8000_0402, "R6 edge flag held");
        chk("R9 edge src1 par", 32'(par_irq), 32'hE);
        wr(8'h40, 32'h2, 4'hF);
        rd(8'h40, 32'h8000_0400, "R6 flag cleared");

        // R7 capture and clear in the same cycle
        @(negedge clk); irq_in[1] = 1'b1;
        @(negedge clk); irq_in[1] = 1'b0;
        wait_neg(4);
        @(negedge clk); irq_in[1] = 1'b1;
        wait_neg(2);
        bus_wen = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h2; bus_be = 4'hF;
        @(negedge clk);
        bus_wen = 1'b0; bus_be = '0;
        rd(8'h40, 32'h8000_0402, "R7 capture beats clear");

        // R6 level mode discards the flag
        @(negedge clk); irq_in[1] = 1'b0;
        wait_neg(3);
        wr(8'h34, 32'h0, 4'hF);
        wr(8'h34, 32'h2, 4'hF);
        rd(8'h40, 32'h8000_0400, "R6 flag discarded");

        // R5 falling edge
        wr(8'h30, 32'h7FFF_FFFD, 4'hF);
        @(negedge clk); irq_in[1] = 1'b1;
        wait_neg(4);
        rd(8'h40, 32'h8000_0400, "R5 rise ignored when falling");
        @(negedge clk); irq_in[1] = 1'b0;
        wait_neg(4);
        rd(8'h40, 32'h8000_0402, "R5 falling captured");

        wait_neg(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule